// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe, a divided pixel clock and a one-cycle pixel clock-enable. It also gives the column and row of the current active pixel, so that a pixel source upstream can fetch the right data. Each horizontal and vertical segment length, and the divide ratio, is held on configuration inputs as the count minus one. Each output level can be inverted on its own.

A line is made of four segments in a fixed order: sync pulse, back porch, active pixels, front porch. A frame is made of the same four segments counted in lines. The timing counters advance only on the pixel clock-enable. A run controller starts output when video is enabled. It lets a stop request mid-frame take effect only after the last pixel of the frame. It can also raise a one-cycle frame interrupt when the raster arrives at a chosen vertical segment.

The run controller has three states:
- `RUN_IDLE`: output is parked at inactive levels and the counters wait at the first pixel of the frame. It moves to `RUN_LIVE` on a pixel enable while video is enabled.
- `RUN_LIVE`: the raster runs. When video is disabled it moves to `RUN_IDLE` if that edge ends the frame, and to `RUN_DRAIN` otherwise.
- `RUN_DRAIN`: the raster keeps running. It returns to `RUN_LIVE` if video is enabled again, and otherwise moves to `RUN_IDLE` at the frame end.

Each of the two segment sequencers steps through `SEG_SYNC` → `SEG_BACK` → `SEG_ACT` → `SEG_FRONT` → `SEG_SYNC`. It leaves a segment when the position inside it reaches that segment's programmed length.

Top module: `panel_timing_gen`

## Requirements
- R1: After reset and while stopped, hsync, vsync and de sit at their inactive levels, pix_x and pix_y are 0 and frame_irq is 0.
- R2: pix_ce is high for one clk cycle in every div_m1+1 cycles. The first pulse comes div_m1 cycles after reset ends. div_m1 is 8 bits wide, so the ratio reaches 256.
- R3: Before inversion, pclk is high while the divider count (0 to div_m1, counting clk cycles since the last pix_ce) is greater than div_m1>>1.
- R4: Each line lasts (hsw_m1+1)+(hbp_m1+1)+(hact_m1+1)+(hfp_m1+1) pixel enables. hsync is active for the first hsw_m1+1 of them, followed in order by back porch, active pixels and front porch. The counters move only on pix_ce.
- R5: Each frame has the same four-segment order in lines. vsync is active for the first vsw_m1+1 lines, followed by vbp_m1+1, vact_m1+1 and vfp_m1+1 lines.
- R6: de is active only where the line and the frame are both in their active segments. There, pix_x and pix_y count from 0; elsewhere both are 0.
- R7: hsync, vsync, de and pclk are each XORed with their own invert input (inv_hsync, inv_vsync, inv_de, inv_pclk). A value of 1 makes that output active-low.
- R8: With video_en high while stopped, output starts at the next pix_ce edge, at the first pixel of the sync segment of the frame's first line.
- R9: Dropping video_en stops output only after the last pixel of the frame. Raising video_en again before then cancels the stop.
- R10: frame_irq pulses for one clk cycle when the raster arrives at pixel 0 of the first line of the vertical segment chosen by irq_sel (0 sync, 1 back porch, 2 active, 3 front porch). This includes the arrival at the first pixel when output starts.
- R11: With irq_en low, frame_irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| video_en | input | 1 | Start (1) or request stop (0) of output |
| div_m1 | input | DIV_W | Pixel clock divide ratio minus one |
| hsw_m1 | input | CNT_W | Horizontal sync width minus one |
| hbp_m1 | input | CNT_W | Horizontal back porch minus one |
| hact_m1 | input | CNT_W | Active pixels per line minus one |
| hfp_m1 | input | CNT_W | Horizontal front porch minus one |
| vsw_m1 | input | CNT_W | Vertical sync width in lines minus one |
| vbp_m1 | input | CNT_W | Vertical back porch minus one |
| vact_m1 | input | CNT_W | Active lines minus one |
| vfp_m1 | input | CNT_W | Vertical front porch minus one |
| inv_hsync | input | 1 | Invert hsync |
| inv_vsync | input | 1 | Invert vsync |
| inv_de | input | 1 | Invert de |
| inv_pclk | input | 1 | Invert pclk |
| irq_en | input | 1 | Gate for frame_irq |
| irq_sel | input | 2 | Vertical segment that raises frame_irq |
| pclk | output | 1 | Divided pixel clock |
| pix_ce | output | 1 | One-cycle pixel clock-enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | CNT_W | Active pixel column |
| pix_y | output | CNT_W | Active line row |
| frame_irq | output | 1 | Frame interrupt pulse |

## Verification
The bench sweeps several small timing sets, one per irq_sel value, with divide ratios of 1 to 4 and with 256. At every clk cycle it compares each output with a raster position computed arithmetically. An off-by-one in the minus-one fields would stretch or shorten a segment by one pixel or line. A divider that wraps one count early would shift every pix_ce, and a frame that ends at the wrong count would misplace every sync. A stop dropped mid-frame, one cancelled before the frame end, and a start arriving between pixel enables are all driven. A design that halts at once, ignores the cancel, or starts on a non-enable cycle shows a wrong level at the very next sample. The interrupt is checked on the frame start edge and at each segment, and again with its gate off.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_ACT   = 2'd2,
        SEG_FRONT = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_LIVE  = 2'd1,
        RUN_DRAIN = 2'd2
    } run_e;

endpackage

// File: rtl/dtg_clk_div.sv
module dtg_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick,
    output logic             phase_hi
);

    logic [DIV_W-1:0] cnt;

    // wrap on >= so a ratio lowered mid-period recovers at once
    assign tick     = (cnt >= div_m1);
    assign phase_hi = (cnt > (div_m1 >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dtg_segment_seq.sv
module dtg_segment_seq
    import dtg_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [CNT_W-1:0] sync_m1,
    input  logic [CNT_W-1:0] back_m1,
    input  logic [CNT_W-1:0] act_m1,
    input  logic [CNT_W-1:0] front_m1,
    output seg_e             seg,
    output logic [CNT_W-1:0] pos,
    output logic             wrap
);

    seg_e             seg_nx;
    logic [CNT_W-1:0] cur_len;
    logic             seg_done;

    always_comb begin
        cur_len = sync_m1;
        seg_nx  = SEG_SYNC;
        unique case (seg)
            SEG_SYNC:  begin cur_len = sync_m1;  seg_nx = SEG_BACK;  end
            SEG_BACK:  begin cur_len = back_m1;  seg_nx = SEG_ACT;   end
            SEG_ACT:   begin cur_len = act_m1;   seg_nx = SEG_FRONT; end
            SEG_FRONT: begin cur_len = front_m1; seg_nx = SEG_SYNC;  end
            default:   begin cur_len = sync_m1;  seg_nx = SEG_SYNC;  end
        endcase
    end

    assign seg_done = (pos >= cur_len);
    assign wrap     = step && (seg == SEG_FRONT) && seg_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg <= SEG_SYNC;
            pos <= '0;
        end else if (step) begin
            if (seg_done) begin
                seg <= seg_nx;
                pos <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dtg_run_ctrl.sv
module dtg_run_ctrl
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic video_en,
    input  logic tick,
    input  logic frame_end,
    output logic live,
    output logic start
);

    run_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RUN_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            RUN_IDLE: begin
                if (video_en && tick) st_nx = RUN_LIVE;
            end
            RUN_LIVE: begin
                if (!video_en) st_nx = frame_end ? RUN_IDLE : RUN_DRAIN;
            end
            RUN_DRAIN: begin
                if (video_en)       st_nx = RUN_LIVE;
                else if (frame_end) st_nx = RUN_IDLE;
            end
            default: st_nx = RUN_IDLE;
        endcase
    end

    assign live  = (st != RUN_IDLE);
    assign start = (st == RUN_IDLE) && (st_nx == RUN_LIVE);

endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import dtg_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             video_en,
    input  logic [DIV_W-1:0] div_m1,
    input  logic [CNT_W-1:0] hsw_m1,
    input  logic [CNT_W-1:0] hbp_m1,
    input  logic [CNT_W-1:0] hact_m1,
    input  logic [CNT_W-1:0] hfp_m1,
    input  logic [CNT_W-1:0] vsw_m1,
    input  logic [CNT_W-1:0] vbp_m1,
    input  logic [CNT_W-1:0] vact_m1,
    input  logic [CNT_W-1:0] vfp_m1,
    input  logic             inv_hsync,
    input  logic             inv_vsync,
    input  logic             inv_de,
    input  logic             inv_pclk,
    input  logic             irq_en,
    input  logic [1:0]       irq_sel,
    output logic             pclk,
    output logic             pix_ce,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [CNT_W-1:0] pix_x,
    output logic [CNT_W-1:0] pix_y,
    output logic             frame_irq
);

    localparam logic [CNT_W-1:0] POS_ZERO = '0;

    logic             tick, phase_hi;
    logic             live, start;
    logic             h_step, h_wrap, v_wrap;
    seg_e             h_seg, v_seg;
    logic [CNT_W-1:0] h_pos, v_pos;
    logic             moved;
    logic             at_point, in_active;

    dtg_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_m1   (div_m1),
        .tick     (tick),
        .phase_hi (phase_hi)
    );

    assign h_step = tick && live;

    dtg_segment_seq #(.CNT_W(CNT_W)) u_hseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (h_step),
        .sync_m1  (hsw_m1),
        .back_m1  (hbp_m1),
        .act_m1   (hact_m1),
        .front_m1 (hfp_m1),
        .seg      (h_seg),
        .pos      (h_pos),
        .wrap     (h_wrap)
    );

    dtg_segment_seq #(.CNT_W(CNT_W)) u_vseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (h_wrap),
        .sync_m1  (vsw_m1),
        .back_m1  (vbp_m1),
        .act_m1   (vact_m1),
        .front_m1 (vfp_m1),
        .seg      (v_seg),
        .pos      (v_pos),
        .wrap     (v_wrap)
    );

    dtg_run_ctrl u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .video_en  (video_en),
        .tick      (tick),
        .frame_end (v_wrap),
        .live      (live),
        .start     (start)
    );

    // raster position changed at the last edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            moved <= 1'b0;
        end else begin
            moved <= h_step || start;
        end
    end

    always_comb begin
        in_active = live && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);
        at_point  = live && (v_seg == seg_e'(irq_sel)) && (v_pos == POS_ZERO)
                    && (h_seg == SEG_SYNC) && (h_pos == POS_ZERO);
        pclk      = phase_hi ^ inv_pclk;
        pix_ce    = tick;
        hsync     = (live && (h_seg == SEG_SYNC)) ^ inv_hsync;
        vsync     = (live && (v_seg == SEG_SYNC)) ^ inv_vsync;
        de        = in_active ^ inv_de;
        pix_x     = in_active ? h_pos : POS_ZERO;
        pix_y     = in_active ? v_pos : POS_ZERO;
        frame_irq = irq_en && moved && at_point;
    end

endmodule

// File: rtl/panel_timing_gen_chk.sv
module panel_timing_gen_chk #(
    parameter int CNT_W = 11,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_m1,
    input logic             inv_hsync,
    input logic             inv_vsync,
    input logic             inv_de,
    input logic             pix_ce,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic [CNT_W-1:0] pix_x,
    input logic [CNT_W-1:0] pix_y,
    input logic             frame_irq
);

    AST_DE_EXCLUDES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (de ^ inv_de) |-> (!(hsync ^ inv_hsync) && !(vsync ^ inv_vsync))); // R6

    AST_COORD_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(de ^ inv_de) |-> (pix_x == '0 && pix_y == '0)); // R6

    AST_X_HOLDS_BETWEEN_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ce |=> $stable(pix_x)); // R4

    AST_PCE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> (!pix_ce || div_m1 == '0)); // R2

    AST_IRQ_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |-> ((hsync ^ inv_hsync) && !(de ^ inv_de))); // R10

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |=> !frame_irq); // R10

endmodule

bind panel_timing_gen panel_timing_gen_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/panel_timing_gen_bench.sv
module panel_timing_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 11;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          video_en = 1'b0;
    logic [DW-1:0] div_m1 = '0;
    logic [CW-1:0] hsw_m1 = '0, hbp_m1 = '0, hact_m1 = '0, hfp_m1 = '0;
    logic [CW-1:0] vsw_m1 = '0, vbp_m1 = '0, vact_m1 = '0, vfp_m1 = '0;
    logic          inv_hsync = 1'b0, inv_vsync = 1'b0, inv_de = 1'b0, inv_pclk = 1'b0;
    logic          irq_en = 1'b1;
    logic [1:0]    irq_sel = 2'd0;
    logic          pclk, pix_ce, hsync, vsync, de, frame_irq;
    logic [CW-1:0] pix_x, pix_y;

    panel_timing_gen #(.CNT_W(CW), .DIV_W(DW)) u_panel_timing_gen (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int hs, hb, ha, hf, vs, vb, va, vf, ratio, sel;
    bit ih, iv, id, ip, ie;
    bit run_m, moved_m;
    int k, c, irq_seen;

    task automatic chk(input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    function automatic int seg_of(input int p, input int a, input int b, input int d);
        if (p < a) return 0;
        if (p < a + b) return 1;
        if (p < a + b + d) return 2;
        return 3;
    endfunction

    task automatic check_outputs(input string tag);
        int ht, h, ln, hp, vp, cnt, fl, ex, ey;
        bit dea;
        ht  = hs + hb + ha + hf;
        h   = k % ht;
        ln  = k / ht;
        hp  = seg_of(h, hs, hb, ha);
        vp  = seg_of(ln, vs, vb, va);
        dea = run_m && hp == 2 && vp == 2;
        ex  = dea ? h - hs - hb : 0;
        ey  = dea ? ln - vs - vb : 0;
        fl  = (sel == 0) ? 0 : (sel == 1) ? vs : (sel == 2) ? vs + vb : vs + vb + va;
        cnt = c % ratio;
        chk({"R2 pix_ce ", tag}, pix_ce, cnt == ratio - 1);
        chk({"R3 pclk ", tag}, pclk, (cnt > (ratio - 1) / 2) ^ ip);
        chk({"R4 hsync ", tag}, hsync, (run_m && hp == 0) ^ ih);
        chk({"R5 vsync ", tag}, vsync, (run_m && vp == 0) ^ iv);
        chk({"R6 de ", tag}, de, dea ^ id);
        chk({"R6 pix_x ", tag}, pix_x, ex);
        chk({"R6 pix_y ", tag}, pix_y, ey);
        chk({"R10 frame_irq ", tag}, frame_irq,
            ie && moved_m && run_m && h == 0 && ln == fl);
    endtask

    task automatic step1(input string tag);
        bit en_s, pce_s;
        int ft;
        en_s  = video_en;
        pce_s = pix_ce;
        ft    = (hs + hb + ha + hf) * (vs + vb + va + vf);
        @(negedge clk);
        c++;
        moved_m = 1'b0;
        if (pce_s) begin
            if (run_m) begin
                k++;
                moved_m = 1'b1;
                if (k == ft) begin
                    k = 0;
                    if (!en_s) run_m = 1'b0;
                end
            end else if (en_s) begin
                run_m   = 1'b1;
                k       = 0;
                moved_m = 1'b1;
            end
        end
        if (frame_irq) irq_seen++;
        check_outputs(tag);
    endtask

    task automatic step_n(input int n, input string tag);
        for (int i = 0; i < n; i++) step1(tag);
    endtask

    task automatic do_reset(input int i);
        rst_n    = 1'b0;
        video_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (i < 4) begin
            hs = 1 + i % 2; hb = 1 + i; ha = 3 + i; hf = 1 + (i + 1) % 2;
            vs = 1 + i % 2; vb = 1 + i / 2; va = 2 + i; vf = 1 + (i + 1) % 2;
            ratio = i + 1; sel = i;
            ih = i[0]; iv = i[1]; id = i[0] ^ i[1]; ip = !i[0];
        end else begin
            hs = 1; hb = 1; ha = 2; hf = 1; vs = 1; vb = 1; va = 2; vf = 1;
            ratio = 256; sel = 0;
            ih = 1'b0; iv = 1'b0; id = 1'b0; ip = 1'b0;
        end
        ie = 1'b1;
        hsw_m1 = CW'(hs - 1); hbp_m1 = CW'(hb - 1); hact_m1 = CW'(ha - 1); hfp_m1 = CW'(hf - 1);
        vsw_m1 = CW'(vs - 1); vbp_m1 = CW'(vb - 1); vact_m1 = CW'(va - 1); vfp_m1 = CW'(vf - 1);
        div_m1 = DW'(ratio - 1);
        inv_hsync = ih; inv_vsync = iv; inv_de = id; inv_pclk = ip;
        irq_en = ie; irq_sel = 2'(sel);
        @(negedge clk);
        rst_n = 1'b1;
        c = 0; k = 0; run_m = 1'b0; moved_m = 1'b0;
        check_outputs("R1 after reset");
        chk("R7 idle hsync level", hsync, ih);
        chk("R7 idle vsync level", vsync, iv);
        chk("R7 idle de level", de, id);
    endtask

    initial begin
        int ft;
        for (int i = 0; i < 4; i++) begin
            do_reset(i);
            ft = (hs + hb + ha + hf) * (vs + vb + va + vf) * ratio;
            step_n(7, "R1 idle");
            video_en = 1'b1;
            step_n(ft + 5, "R8 start");
            video_en = 1'b0;
            step_n((hs + hb + ha + hf) * ratio * 2, "R9 stop pending");
            if (i == 1) video_en = 1'b1;
            step_n(ft * 2, "R9 drain");
            if (i != 1) begin
                chk("R9 stopped hsync level", hsync, ih);
                chk("R9 stopped de level", de, id);
            end
            video_en = 1'b1;
            irq_en   = 1'b0;
            ie       = 1'b0;
            irq_seen = 0;
            step_n(ft * 2, "R11 gated");
            chk("R11 interrupts while gated", irq_seen, 0);
            irq_en   = 1'b1;
            ie       = 1'b1;
            irq_seen = 0;
            step_n(ft, "R10 one frame");
            chk("R10 interrupts per frame", irq_seen, 1);
        end
        do_reset(4);
        video_en = 1'b1;
        step_n(256 * 6, "R2 max ratio");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule